// File: doc/BRIEF.md
# Precise Event Sampling Assist Engine

This block turns performance-counter overflows into sampled records. It holds a small bank of down-counters, and each one watches its own event input. A counter is configured as either precise or plain. When a counter runs down to zero it sets its bit in a global status word. A precise counter then arms a per-counter assist after a programmable delay. The next event seen by an armed counter causes a record to be written. The record carries a raw snapshot of the whole status word and a tag that names the counters whose assists fired.

The status snapshot is raw. It can include bits from counters that are unrelated to the trigger, and triggers from several armed counters that fall inside a configurable closeness window collapse into a single record. Records go out through a write port as a slot address, which is the base plus the write index times the record size. A level interrupt is raised once the number of buffered records reaches a programmable threshold. When the buffer is full, further captures are dropped and a sticky overflow flag is set.

Top module: `precise_sample_engine`

## Requirements
- R1: A pulse on `ctr_load[n]` copies counter n's reload value into the counter, clears status bit n and returns the counter to idle. After that, each cycle with `evt[n]` high decrements a nonzero idle counter by one. The event that takes the counter from 1 to 0 sets `status[n]`, which is bit n of the status word. A counter holding zero does not count.
- R2: A precise counter that overflows raises `assist_armed[n]` exactly D clock edges after the edge that recorded the overflow, where D is `cfg_arm_delay`, and a value of 0 behaves as 1. Events that arrive during the arming delay are ignored.
- R3: A plain counter sets its status bit on overflow but never arms and never produces a record. With reload enabled it reloads at the overflow edge, and its status bit stays set.
- R4: The first event on an armed counter is a trigger. The record it produces carries `rec_status`, equal to the status word as it stood in the cycle the record closed, including bits of unrelated counters. It also carries `rec_tag`, with bit n set for each counter whose trigger is in the record.
- R5: When a record is written, the status bits of the tagged counters clear. Each tagged counter reloads if `cfg_reload_en[n]` is set. Otherwise it stays at zero and does not overflow again until it is loaded.
- R6: With closeness window W, triggers sampled on the edge of the first trigger and on the W following edges merge into one record. That record is written at the edge W cycles after the first trigger. A trigger that comes later opens a new record.
- R7: With W = 0, only triggers sampled on the same edge merge into one record. Triggers one cycle apart give two records.
- R8: The k-th record written since reset (k from 0) goes to `rec_addr` = `cfg_base` + k × REC_WORDS, and `rec_count` then equals k+1.
- R9: `irq` is high exactly when `cfg_threshold` is nonzero and `rec_count` is at least `cfg_threshold`. It rises in the same cycle as the write that reaches the threshold.
- R10: Once `rec_count` equals DEPTH, a closing record is not written. Instead `buf_ovf` sets and stays set until reset.
- R11: After reset the status word, the armed flags, `rec_we`, `rec_count`, `irq` and `buf_ovf` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_precise | input | N_CTR | Per counter: 1 = precise, 0 = plain |
| cfg_reload_en | input | N_CTR | Per counter auto-reload enable |
| cfg_reload_val | input | N_CTR*CTR_W | Reload values, counter n at bits [n*CTR_W +: CTR_W] |
| cfg_arm_delay | input | DLY_W | Arming delay in cycles (0 treated as 1) |
| cfg_threshold | input | CNT_W | Record count that raises the interrupt (0 disables) |
| cfg_base | input | ADDR_W | Buffer base address |
| ctr_load | input | N_CTR | Load counter from reload value and clear its state |
| evt | input | N_CTR | Per-counter event input |
| status | output | N_CTR | Global overflow status word |
| assist_armed | output | N_CTR | Per-counter assist armed |
| rec_we | output | 1 | Record write strobe |
| rec_addr | output | ADDR_W | Slot address of the record |
| rec_status | output | N_CTR | Status snapshot in the record |
| rec_tag | output | N_CTR | Counters whose triggers formed the record |
| rec_count | output | CNT_W | Records written since reset |
| irq | output | 1 | Threshold interrupt (level) |
| buf_ovf | output | 1 | Sticky dropped-record flag |

## Verification
The bench builds two copies with four 8-bit counters and a four-record buffer, driven in parallel. One copy has a window of 2 and the other a window of 0. This puts every trigger gap from 0 to 4 cycles on both sides of each window edge. The small buffer lets each threshold value from 0 to 4 be swept up to and past the full point. A 4-bit delay field lets every arming delay from 0 to 3 be timed exactly.

// File: rtl/pse_pkg.sv
package pse_pkg;

  // Assist lifecycle of one counter
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,  // counting events
    ST_ARMING = 2'd1,  // overflowed, assist delay running
    ST_ARMED  = 2'd2,  // next event triggers
    ST_WAIT   = 2'd3   // triggered, held until its record closes
  } pse_state_e;

endpackage

// File: rtl/pse_ctr_unit.sv
module pse_ctr_unit
  import pse_pkg::*;
#(
  parameter int CTR_W = 8,
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             is_precise,
  input  logic             reload_en,
  input  logic [CTR_W-1:0] reload_val,
  input  logic             load,
  input  logic             evt,
  input  logic [DLY_W-1:0] arm_delay,
  input  logic             retire,
  output logic             trig,
  output logic             ovf,
  output logic             armed,
  output logic             status
);

  logic [CTR_W-1:0] cnt_q;
  logic [DLY_W-1:0] tmr_q;
  pse_state_e       st_q;
  logic             stat_q;
  logic             counting;

  // Value taken after a record or a plain overflow
  function automatic logic [CTR_W-1:0] after_wrap(input logic en, input logic [CTR_W-1:0] rv);
    return en ? rv : '0;
  endfunction

  // Delay of zero is promoted to one cycle
  function automatic logic [DLY_W-1:0] eff_delay(input logic [DLY_W-1:0] d);
    return (d == '0) ? DLY_W'(1) : d;
  endfunction

  assign counting = (st_q == ST_IDLE) && evt && (cnt_q != '0);
  assign ovf      = counting && (cnt_q == CTR_W'(1));
  assign trig     = (st_q == ST_ARMED) && evt;
  assign armed    = (st_q == ST_ARMED);
  assign status   = stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tmr_q  <= '0;
      st_q   <= ST_IDLE;
      stat_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= reload_val;
      tmr_q  <= '0;
      st_q   <= ST_IDLE;
      stat_q <= 1'b0;
    end else if (retire) begin
      cnt_q  <= after_wrap(reload_en, reload_val);
      st_q   <= ST_IDLE;
      stat_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (ovf) begin
            stat_q <= 1'b1;
            if (is_precise) begin
              cnt_q <= '0;
              tmr_q <= eff_delay(arm_delay);
              st_q  <= ST_ARMING;
            end else begin
              cnt_q <= after_wrap(reload_en, reload_val);
            end
          end else if (counting) begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ARMING: begin
          if (tmr_q <= DLY_W'(1)) st_q <= ST_ARMED;
          else                    tmr_q <= tmr_q - 1'b1;
        end
        ST_ARMED: begin
          if (trig) st_q <= ST_WAIT;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pse_merge.sv
module pse_merge #(
  parameter int N   = 4,
  parameter int WIN = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  output logic         close,
  output logic [N-1:0] tag,
  output logic [N-1:0] retire
);

  generate
    if (WIN == 0) begin : g_same_cycle
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign close  = |trig;
      assign tag    = trig;
      assign retire = close ? trig : '0;
    end else begin : g_window
      localparam int WCW = $clog2(WIN + 1) + 1;
      logic [N-1:0]   pend_q;
      logic [WCW-1:0] win_q;
      logic [N-1:0]   all_mask;

      assign all_mask = pend_q | trig;
      assign close    = (pend_q != '0) && (win_q == WCW'(1));
      assign tag      = all_mask;
      assign retire   = close ? all_mask : '0;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q <= '0;
          win_q  <= '0;
        end else if (close) begin
          pend_q <= '0;
          win_q  <= '0;
        end else if (pend_q == '0) begin
          if (trig != '0) begin
            pend_q <= trig;
            win_q  <= WCW'(WIN);
          end
        end else begin
          pend_q <= all_mask;
          win_q  <= win_q - 1'b1;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pse_rec_index.sv
module pse_rec_index #(
  parameter int N         = 4,
  parameter int DEPTH     = 4,
  parameter int ADDR_W    = 16,
  parameter int REC_WORDS = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic [N-1:0]      tag,
  input  logic [N-1:0]      snap,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  threshold,
  output logic              rec_we,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [N-1:0]      rec_status,
  output logic [N-1:0]      rec_tag,
  output logic [CNT_W-1:0]  rec_count,
  output logic              irq,
  output logic              buf_ovf
);

  logic [CNT_W-1:0] count_q;
  logic             full;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [CNT_W-1:0]  idx);
    return b + ADDR_W'(idx) * ADDR_W'(REC_WORDS);
  endfunction

  assign full      = (count_q == CNT_W'(DEPTH));
  assign rec_count = count_q;
  assign irq       = (threshold != '0) && (count_q >= threshold);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q    <= '0;
      rec_we     <= 1'b0;
      rec_addr   <= '0;
      rec_status <= '0;
      rec_tag    <= '0;
      buf_ovf    <= 1'b0;
    end else begin
      rec_we <= 1'b0;
      if (close) begin
        if (!full) begin
          rec_we     <= 1'b1;
          rec_addr   <= slot_addr(base, count_q);
          rec_status <= snap;
          rec_tag    <= tag;
          count_q    <= count_q + 1'b1;
        end else begin
          buf_ovf <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/precise_sample_engine.sv
module precise_sample_engine #(
  parameter int N_CTR     = 4,
  parameter int CTR_W     = 8,
  parameter int DLY_W     = 4,
  parameter int WIN       = 2,
  parameter int DEPTH     = 4,
  parameter int ADDR_W    = 16,
  parameter int REC_WORDS = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CTR-1:0]       cfg_precise,
  input  logic [N_CTR-1:0]       cfg_reload_en,
  input  logic [N_CTR*CTR_W-1:0] cfg_reload_val,
  input  logic [DLY_W-1:0]       cfg_arm_delay,
  input  logic [CNT_W-1:0]       cfg_threshold,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [N_CTR-1:0]       ctr_load,
  input  logic [N_CTR-1:0]       evt,
  output logic [N_CTR-1:0]       status,
  output logic [N_CTR-1:0]       assist_armed,
  output logic                   rec_we,
  output logic [ADDR_W-1:0]      rec_addr,
  output logic [N_CTR-1:0]       rec_status,
  output logic [N_CTR-1:0]       rec_tag,
  output logic [CNT_W-1:0]       rec_count,
  output logic                   irq,
  output logic                   buf_ovf
);

  // Named internal events, observed by the bound checker
  logic [N_CTR-1:0] ctr_trig;
  logic [N_CTR-1:0] ctr_ovf;
  logic [N_CTR-1:0] ctr_retire;
  logic             merge_close;
  logic [N_CTR-1:0] merge_tag;

  generate
    for (genvar i = 0; i < N_CTR; i++) begin : g_ctr
      pse_ctr_unit #(
        .CTR_W (CTR_W),
        .DLY_W (DLY_W)
      ) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_precise (cfg_precise[i]),
        .reload_en  (cfg_reload_en[i]),
        .reload_val (cfg_reload_val[i*CTR_W +: CTR_W]),
        .load       (ctr_load[i]),
        .evt        (evt[i]),
        .arm_delay  (cfg_arm_delay),
        .retire     (ctr_retire[i]),
        .trig       (ctr_trig[i]),
        .ovf        (ctr_ovf[i]),
        .armed      (assist_armed[i]),
        .status     (status[i])
      );
    end
  endgenerate

  pse_merge #(
    .N   (N_CTR),
    .WIN (WIN)
  ) u_merge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (ctr_trig),
    .close  (merge_close),
    .tag    (merge_tag),
    .retire (ctr_retire)
  );

  pse_rec_index #(
    .N         (N_CTR),
    .DEPTH     (DEPTH),
    .ADDR_W    (ADDR_W),
    .REC_WORDS (REC_WORDS)
  ) u_index (
    .clk        (clk),
    .rst_n      (rst_n),
    .close      (merge_close),
    .tag        (merge_tag),
    .snap       (status),
    .base       (cfg_base),
    .threshold  (cfg_threshold),
    .rec_we     (rec_we),
    .rec_addr   (rec_addr),
    .rec_status (rec_status),
    .rec_tag    (rec_tag),
    .rec_count  (rec_count),
    .irq        (irq),
    .buf_ovf    (buf_ovf)
  );

endmodule

// File: rtl/pse_checker.sv
module pse_checker #(
  parameter int N     = 4,
  parameter int CNT_W = 3,
  parameter int DEPTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N-1:0]     status,
  input logic [N-1:0]     assist_armed,
  input logic [N-1:0]     ctr_ovf,
  input logic             merge_close,
  input logic             rec_we,
  input logic [CNT_W-1:0] rec_count,
  input logic             buf_ovf
);

  generate
    for (genvar n = 0; n < N; n++) begin : g_bit
      assert_status_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[n]) |-> $past(ctr_ovf[n]));

      assert_armed_has_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(assist_armed[n]) |-> status[n]);
    end
  endgenerate

  assert_write_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |-> $past(merge_close));

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_we |-> (rec_count == $past(rec_count) + 1'b1));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_count <= CNT_W'(DEPTH));

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(buf_ovf) |-> buf_ovf);

  assert_drop_when_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_close && rec_count == CNT_W'(DEPTH)) |=> (!rec_we && buf_ovf));

endmodule

bind precise_sample_engine pse_checker #(
  .N     (N_CTR),
  .CNT_W (CNT_W),
  .DEPTH (DEPTH)
) u_pse_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .status       (status),
  .assist_armed (assist_armed),
  .ctr_ovf      (ctr_ovf),
  .merge_close  (merge_close),
  .rec_we       (rec_we),
  .rec_count    (rec_count),
  .buf_ovf      (buf_ovf)
);

// File: tb/precise_sample_engine_bench.sv
`timescale 1ns/1ps
module precise_sample_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_precise = '0;
  logic [3:0]  cfg_reload_en = '0;
  logic [31:0] cfg_reload_val = '0;
  logic [3:0]  cfg_arm_delay = '0;
  logic [2:0]  cfg_threshold = '0;
  logic [15:0] cfg_base = 16'h0100;
  logic [3:0]  ctr_load = '0;
  logic [3:0]  evt = '0;

  // Copy A: window 2.  Copy B: window 0.
  logic [3:0]  a_status, a_armed, a_rst, a_rtag, b_status, b_armed, b_rst, b_rtag;
  logic        a_we, a_irq, a_ovf, b_we, b_irq, b_ovf;
  logic [15:0] a_addr, b_addr;
  logic [2:0]  a_count, b_count;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  always #10 clk = ~clk;  // 50 MHz
  always @(posedge clk) cyc <= cyc + 1;

  precise_sample_engine #(.WIN(2)) u_precise_sample_engine (
    .clk(clk), .rst_n(rst_n), .cfg_precise(cfg_precise), .cfg_reload_en(cfg_reload_en),
    .cfg_reload_val(cfg_reload_val), .cfg_arm_delay(cfg_arm_delay),
    .cfg_threshold(cfg_threshold), .cfg_base(cfg_base), .ctr_load(ctr_load), .evt(evt),
    .status(a_status), .assist_armed(a_armed), .rec_we(a_we), .rec_addr(a_addr),
    .rec_status(a_rst), .rec_tag(a_rtag), .rec_count(a_count), .irq(a_irq), .buf_ovf(a_ovf));

  precise_sample_engine #(.WIN(0)) u_same (
    .clk(clk), .rst_n(rst_n), .cfg_precise(cfg_precise), .cfg_reload_en(cfg_reload_en),
    .cfg_reload_val(cfg_reload_val), .cfg_arm_delay(cfg_arm_delay),
    .cfg_threshold(cfg_threshold), .cfg_base(cfg_base), .ctr_load(ctr_load), .evt(evt),
    .status(b_status), .assist_armed(b_armed), .rec_we(b_we), .rec_addr(b_addr),
    .rec_status(b_rst), .rec_tag(b_rtag), .rec_count(b_count), .irq(b_irq), .buf_ovf(b_ovf));

  // Record logs taken at the port
  int a_n = 0, b_n = 0;
  logic [3:0]  a_ls [0:63], a_lt [0:63], b_ls [0:63], b_lt [0:63];
  logic [15:0] a_la [0:63], b_la [0:63];
  logic        a_li [0:63], b_li [0:63], a_lo [0:63], b_lo [0:63];
  int          a_lc [0:63], b_lc [0:63];

  always @(negedge clk) begin
    if (rst_n && a_we && a_n < 64) begin
      a_ls[a_n] = a_rst; a_lt[a_n] = a_rtag; a_la[a_n] = a_addr;
      a_li[a_n] = a_irq; a_lo[a_n] = a_ovf; a_lc[a_n] = cyc; a_n = a_n + 1;
    end
    if (rst_n && b_we && b_n < 64) begin
      b_ls[b_n] = b_rst; b_lt[b_n] = b_rtag; b_la[b_n] = b_addr;
      b_li[b_n] = b_irq; b_lo[b_n] = b_ovf; b_lc[b_n] = cyc; b_n = b_n + 1;
    end
  end

  int a0, b0;

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] prec, input logic [3:0] rl,
                          input logic [3:0] dly, input logic [2:0] thr);
    evt = '0; ctr_load = '0;
    cfg_precise = prec; cfg_reload_en = rl; cfg_arm_delay = dly; cfg_threshold = thr;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ctr_load = '1;
    @(negedge clk);
    ctr_load = '0;
    a0 = a_n; b0 = b_n;
  endtask

  task automatic pulse(input logic [3:0] m);
    evt = m;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 status", a_status | b_status, 0);
    check("R11 armed", a_armed | b_armed, 0);
    check("R11 rec_we", a_we | b_we, 0);
    check("R11 rec_count", a_count | b_count, 0);
    check("R11 irq", a_irq | b_irq, 0);
    check("R11 buf_ovf", a_ovf | b_ovf, 0);

    // R1: overflow after exactly reload-value events
    for (int r = 1; r <= 4; r++) begin
      cfg_reload_val = 32'(r);
      do_reset(4'b0000, 4'b0000, 4'd1, 3'd0);
      for (int e = 1; e <= r; e++) begin
        pulse(4'b0001);
        check("R1 status after event", a_status[0], (e == r) ? 1 : 0);
        check("R1 status after event (w0)", b_status[0], (e == r) ? 1 : 0);
      end
      pulse(4'b0001);
      check("R1 held at zero", a_status, 1);
    end

    // R2 + R4: arming delay sweep, events ignored while arming
    for (int d = 0; d <= 3; d++) begin
      int eff;
      int t0;
      eff = (d == 0) ? 1 : d;
      cfg_reload_val = 32'h0000_0001;
      do_reset(4'b0001, 4'b0001, 4'(d), 3'd0);
      pulse(4'b0001);
      check("R2 not armed at overflow", a_armed, 0);
      for (int j = 1; j <= eff; j++) begin
        evt = (j < eff) ? 4'b0001 : 4'b0000;
        @(negedge clk);
        evt = '0;
        check("R2 armed timing", a_armed[0], (j == eff) ? 1 : 0);
        check("R2 armed timing (w0)", b_armed[0], (j == eff) ? 1 : 0);
      end
      check("R2 no record while arming", (a_n - a0) + (b_n - b0), 0);
      pulse(4'b0001);
      t0 = cyc;
      check("R4 write strobe (w0)", b_we, 1);
      check("R4 snapshot (w0)", b_rst, 4'b0001);
      check("R4 tag (w0)", b_rtag, 4'b0001);
      repeat (3) @(negedge clk);
      check("R6 one record", a_n - a0, 1);
      check("R6 write edge", a_lc[a0], t0 + 2);
    end

    // R3 + R4 + R5: plain counter bits appear in an unrelated snapshot
    cfg_reload_val = 32'h0000_0101;
    do_reset(4'b0001, 4'b0011, 4'd3, 3'd0);
    pulse(4'b0001);
    pulse(4'b0010);
    check("R3 plain status set", a_status, 4'b0011);
    repeat (2) @(negedge clk);
    check("R3 only precise armed", a_armed, 4'b0001);
    check("R3 only precise armed (w0)", b_armed, 4'b0001);
    pulse(4'b0010);
    check("R3 plain no record", (a_n - a0) + (b_n - b0), 0);
    check("R3 plain never arms", a_armed[1], 0);
    pulse(4'b0001);
    check("R4 unrelated bit in snapshot (w0)", b_rst, 4'b0011);
    check("R4 tag only trigger (w0)", b_rtag, 4'b0001);
    check("R5 own bit cleared (w0)", b_status, 4'b0010);
    repeat (4) @(negedge clk);
    check("R4 unrelated bit in snapshot", a_ls[a0], 4'b0011);
    check("R4 tag only trigger", a_lt[a0], 4'b0001);
    check("R5 own bit cleared", a_status, 4'b0010);
    check("R3 single record", a_n - a0, 1);

    // R5: reload after record
    cfg_reload_val = 32'h0000_0002;
    do_reset(4'b0001, 4'b0001, 4'd1, 3'd0);
    pulse(4'b0001); pulse(4'b0001);
    @(negedge clk);
    pulse(4'b0001);
    repeat (3) @(negedge clk);
    check("R5 cleared after record", a_status | b_status, 0);
    pulse(4'b0001);
    check("R5 reloaded counts again", a_status | b_status, 0);
    pulse(4'b0001);
    check("R5 reload overflow", a_status[0], 1);
    check("R5 reload overflow (w0)", b_status[0], 1);

    // R5: no reload, counter stays at zero
    do_reset(4'b0001, 4'b0000, 4'd1, 3'd0);
    pulse(4'b0001); pulse(4'b0001);
    @(negedge clk);
    pulse(4'b0001);
    repeat (3) @(negedge clk);
    repeat (4) pulse(4'b0001);
    check("R5 no reload stays idle", a_status | b_status | a_armed | b_armed, 0);
    check("R5 no reload single record", (a_n - a0) + (b_n - b0), 2);

    // R6 + R7: trigger gap sweep against both windows
    for (int g = 0; g <= 4; g++) begin
      int t0;
      int am, bm;
      cfg_reload_val = 32'h0000_0101;
      do_reset(4'b0011, 4'b0011, 4'd1, 3'd0);
      pulse(4'b0011);
      @(negedge clk);
      check("R6 both armed", a_armed, 4'b0011);
      if (g == 0) begin
        pulse(4'b0011);
        t0 = cyc;
      end else begin
        pulse(4'b0001);
        t0 = cyc;
        repeat (g - 1) @(negedge clk);
        pulse(4'b0010);
      end
      repeat (6) @(negedge clk);
      am = (g <= 2) ? 1 : 0;
      bm = (g == 0) ? 1 : 0;
      check("R6 record count", a_n - a0, am ? 1 : 2);
      check("R6 first snapshot", a_ls[a0], 4'b0011);
      check("R6 first tag", a_lt[a0], am ? 4'b0011 : 4'b0001);
      check("R6 first write edge", a_lc[a0], t0 + 2);
      if (!am) begin
        check("R6 second tag", a_lt[a0+1], 4'b0010);
        check("R6 second snapshot", a_ls[a0+1], 4'b0010);
      end
      check("R7 record count", b_n - b0, bm ? 1 : 2);
      check("R7 first tag", b_lt[b0], bm ? 4'b0011 : 4'b0001);
      check("R7 first write edge", b_lc[b0], t0);
      if (!bm) check("R7 second snapshot", b_ls[b0+1], 4'b0010);
    end

    // R8 + R9 + R10: threshold sweep past the full point
    for (int thr = 0; thr <= 4; thr++) begin
      cfg_reload_val = 32'h0000_0001;
      do_reset(4'b0001, 4'b0001, 4'd1, 3'(thr));
      evt = 4'b0001;
      repeat (40) @(negedge clk);
      evt = '0;
      @(negedge clk);
      check("R10 records capped", a_n - a0, 4);
      check("R10 records capped (w0)", b_n - b0, 4);
      for (int i = 0; i < 4; i++) begin
        check("R8 slot address", a_la[a0+i], 16'h0100 + 4 * i);
        check("R8 slot address (w0)", b_la[b0+i], 16'h0100 + 4 * i);
        check("R9 irq at write", a_li[a0+i], (thr != 0 && i + 1 >= thr) ? 1 : 0);
        check("R9 irq at write (w0)", b_li[b0+i], (thr != 0 && i + 1 >= thr) ? 1 : 0);
        check("R10 no overflow before full", a_lo[a0+i], 0);
      end
      check("R8 count", a_count, 4);
      check("R10 overflow flag", a_ovf, 1);
      check("R10 overflow flag (w0)", b_ovf, 1);
      check("R9 irq final", a_irq, (thr != 0) ? 1 : 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule